// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block screens the address field at the head of each received HDLC frame. It works on a byte stream that an upstream stage has already framed and de-stuffed. Three strobes frame that stream: a start-of-frame pulse, a byte-valid qualifier and an end-of-frame pulse. After the last address byte arrives, the filter issues a single accept or reject decision. It also reports which compare values hit, the command/response bit found in the high byte, and whether the frame belongs to the one connection reserved for autonomous handling.

The filter has four address modes. In the first, no comparison is made and every frame passes. In the second, one address byte is compared and the other position is a don't care. In the third, a two-byte address is compared. The fourth is the two-byte mode with auto-connection flagging added. The high byte can hit a fixed group address or either of two programmable values. The low byte can hit either of two more programmable values, so six address combinations are accepted in the two-byte modes.

All configuration inputs are captured on the start-of-frame pulse. A change to them during a frame therefore has no effect on the decision for that frame.

Top module: `hdlc_addr_screen`

## Requirements
- R1: In modes 2 and 3, a frame is accepted only when the first byte hits a high candidate and the second byte equals `lo_set1_i` or `lo_set2_i`. `dec_vld_o` pulses for one cycle, in the cycle after the second byte is presented.
- R2: The code on `hi_hit_o` is 0 for no hit, 1 for the group address, 2 for `hi_set1_i` and 3 for `hi_set2_i`. When several candidates hit, the group address wins, then set1. `lo_hit_o` is 0 for `lo_set1_i` and 1 for `lo_set2_i`, and set1 wins a tie. On a reject, both codes read 0.
- R3: When `cr_en_i` is 1, bit 1 of the high byte is left out of every high compare, so the group address matches 0xFE or 0xFC, and `cr_bit_o` takes that bit. When `cr_en_i` is 0, all high compares are exact, the group address is 0xFE only, and `cr_bit_o` is 0.
- R4: Mode 0 accepts every frame on its first byte. The decision reports hit codes of 0.
- R5: Mode 1 compares only the first byte against the high candidates and decides in the cycle after that byte. `lo_hit_o` is 0.
- R6: Mode 3 decides exactly as mode 2. In mode 3, `auto_conn_o` is 1 only for an accepted frame with high code 2 and low code 0. In every other case it is 0.
- R7: If `eof_i` arrives before the address field is complete, `abort_o` pulses for one cycle and no decision is issued.
- R8: The outputs `cr_bit_o`, `accept_o`, `hi_hit_o`, `lo_hit_o` and `auto_conn_o` hold their decided values until the next `sof_i`, which clears them to 0.
- R9: Mode, `cr_en_i` and all four compare values are sampled on `sof_i`. A change to them later in the same frame does not alter that frame's decision.
- R10: A byte that arrives after the decision, or outside a frame, produces no further decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame pulse, sent on its own cycle before the first byte |
| byte_vld_i | input | 1 | `byte_i` carries a received byte |
| byte_i | input | 8 | De-stuffed received byte |
| eof_i | input | 1 | End-of-frame pulse |
| mode_i | input | 2 | 0 none, 1 one byte, 2 two bytes, 3 two bytes with auto flag |
| cr_en_i | input | 1 | Treat high-byte bit 1 as command/response |
| hi_set1_i | input | 8 | First programmable high compare value |
| hi_set2_i | input | 8 | Second programmable high compare value |
| lo_set1_i | input | 8 | First programmable low compare value |
| lo_set2_i | input | 8 | Second programmable low compare value |
| dec_vld_o | output | 1 | One-cycle decision pulse |
| accept_o | output | 1 | Frame accepted |
| hi_hit_o | output | 2 | High-byte hit code |
| lo_hit_o | output | 1 | Low-byte hit code |
| cr_bit_o | output | 1 | Extracted command/response bit |
| auto_conn_o | output | 1 | Frame is on the auto-handled connection |
| abort_o | output | 1 | One-cycle pulse: frame ended inside its address field |

## Verification
The bench walks all six two-byte combinations. It also covers ties between candidates, the 0xFC group form with the command/response bit masked and unmasked, auto flagging on each non-primary combination, and frames cut short after zero or one byte. A design with the wrong tie order would report the wrong connection. One that ignored the mask would reject 0xFC or a value that differs from a programmed one only in bit 1. A design that decided on a truncated frame would accept garbage instead of aborting. The bench also rewrites the configuration one cycle after start-of-frame and sends a trailing byte after every decision. A filter that does not latch its settings, or that keeps comparing after the decision, then emits a wrong or extra decision.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int CR_POS = 1;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t GROUP_ADDR = 8'hFE;

  typedef enum logic [1:0] {AM_NONE = 2'd0, AM_BYTE = 2'd1, AM_WORD = 2'd2, AM_AUTO = 2'd3} amode_e;
  typedef enum logic [1:0] {HH_NONE = 2'd0, HH_GROUP = 2'd1, HH_SET1 = 2'd2, HH_SET2 = 2'd3} hihit_e;

  typedef struct packed {
    amode_e mode;
    logic   cr_en;
    byte_t  hi1;
    byte_t  hi2;
    byte_t  lo1;
    byte_t  lo2;
  } acfg_t;

  function automatic byte_t cr_mask(input logic cr_en);
    byte_t m;
    m = '1;
    if (cr_en) m[CR_POS] = 1'b0;
    return m;
  endfunction

  function automatic logic masked_eq(input byte_t a, input byte_t b, input logic cr_en);
    return ((a ^ b) & cr_mask(cr_en)) == '0;
  endfunction

  function automatic hihit_e high_hit(input byte_t b, input acfg_t c);
    if (masked_eq(b, GROUP_ADDR, c.cr_en)) return HH_GROUP;
    if (masked_eq(b, c.hi1, c.cr_en))      return HH_SET1;
    if (masked_eq(b, c.hi2, c.cr_en))      return HH_SET2;
    return HH_NONE;
  endfunction

  // {any hit, which: 0 = set1, 1 = set2}
  function automatic logic [1:0] low_hit(input byte_t b, input acfg_t c);
    if (b == c.lo1) return 2'b10;
    if (b == c.lo2) return 2'b11;
    return 2'b00;
  endfunction
endpackage

// File: rtl/hdlc_addr_cfg_latch.sv
module hdlc_addr_cfg_latch
  import hdlc_addr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sof_i,
  input  acfg_t cfg_i,
  output acfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cfg_q <= '0;
    else if (sof_i) cfg_q <= cfg_i;
  end

  // R9: settings move only on start-of-frame
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(cfg_q));
endmodule

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
  import hdlc_addr_pkg::*;
(
  input  byte_t  byte_i,
  input  acfg_t  cfg_i,
  output hihit_e hi_code_o,
  output logic   lo_any_o,
  output logic   lo_sel_o,
  output logic   cr_o
);
  logic [1:0] lo_w;
  assign hi_code_o = high_hit(byte_i, cfg_i);
  assign lo_w      = low_hit(byte_i, cfg_i);
  assign lo_any_o  = lo_w[1];
  assign lo_sel_o  = lo_w[0];
  assign cr_o      = cfg_i.cr_en & byte_i[CR_POS];
endmodule

// File: rtl/hdlc_addr_screen.sv
module hdlc_addr_screen
  import hdlc_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sof_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       eof_i,
  input  logic [1:0] mode_i,
  input  logic       cr_en_i,
  input  logic [7:0] hi_set1_i,
  input  logic [7:0] hi_set2_i,
  input  logic [7:0] lo_set1_i,
  input  logic [7:0] lo_set2_i,
  output logic       dec_vld_o,
  output logic       accept_o,
  output logic [1:0] hi_hit_o,
  output logic       lo_hit_o,
  output logic       cr_bit_o,
  output logic       auto_conn_o,
  output logic       abort_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_DONE} st_e;

  acfg_t  cfg_in, cfg_q;
  hihit_e hi_now, hi_keep;
  logic   lo_any, lo_sel, cr_now, cr_keep;
  st_e    st;

  assign cfg_in = '{mode: amode_e'(mode_i), cr_en: cr_en_i, hi1: hi_set1_i,
                    hi2: hi_set2_i, lo1: lo_set1_i, lo2: lo_set2_i};

  hdlc_addr_cfg_latch u_cfg (.clk(clk), .rst_n(rst_n), .sof_i(sof_i), .cfg_i(cfg_in), .cfg_q(cfg_q));
  hdlc_addr_match u_match (.byte_i(byte_i), .cfg_i(cfg_q), .hi_code_o(hi_now),
                           .lo_any_o(lo_any), .lo_sel_o(lo_sel), .cr_o(cr_now));

  // named internal events
  logic in_addr, addr_byte, single_byte_mode, decide_now, abort_now;
  assign in_addr          = (st == ST_FIRST) || (st == ST_SECOND);
  assign addr_byte        = byte_vld_i && in_addr && !sof_i;
  assign single_byte_mode = (cfg_q.mode == AM_NONE) || (cfg_q.mode == AM_BYTE);
  assign decide_now       = addr_byte && ((st == ST_SECOND) || single_byte_mode);
  assign abort_now        = eof_i && in_addr && !sof_i && !decide_now;

  // decision values
  logic   d_acc, d_lo, d_cr, d_auto;
  hihit_e d_hi;
  always_comb begin
    d_acc = 1'b0; d_hi = HH_NONE; d_lo = 1'b0; d_cr = 1'b0; d_auto = 1'b0;
    unique case (cfg_q.mode)
      AM_NONE: d_acc = 1'b1;
      AM_BYTE: begin
        d_acc = (hi_now != HH_NONE);
        d_hi  = hi_now;
        d_cr  = cr_now;
      end
      default: begin
        d_acc  = (hi_keep != HH_NONE) && lo_any;
        d_hi   = d_acc ? hi_keep : HH_NONE;
        d_lo   = d_acc && lo_sel;
        d_cr   = cr_keep;
        d_auto = (cfg_q.mode == AM_AUTO) && d_acc && (hi_keep == HH_SET1) && !lo_sel;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; hi_keep <= HH_NONE; cr_keep <= 1'b0;
      dec_vld_o <= 1'b0; abort_o <= 1'b0; accept_o <= 1'b0; hi_hit_o <= '0;
      lo_hit_o <= 1'b0; cr_bit_o <= 1'b0; auto_conn_o <= 1'b0;
    end else begin
      dec_vld_o <= decide_now;
      abort_o   <= abort_now;
      if (sof_i) begin
        st <= ST_FIRST;
        accept_o <= 1'b0; hi_hit_o <= '0; lo_hit_o <= 1'b0;
        cr_bit_o <= 1'b0; auto_conn_o <= 1'b0;
      end else begin
        if (addr_byte && st == ST_FIRST && !single_byte_mode) begin
          hi_keep <= hi_now;
          cr_keep <= cr_now;
          st      <= ST_SECOND;
        end
        if (decide_now) begin
          st <= ST_DONE;
          accept_o <= d_acc; hi_hit_o <= d_hi; lo_hit_o <= d_lo;
          cr_bit_o <= d_cr; auto_conn_o <= d_auto;
        end
        if (eof_i) st <= ST_IDLE;
      end
    end
  end

  // R7: abort and decision never coincide
  a_r7_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_o && dec_vld_o));
  // R6: auto flag only on the set1/lo1 pair of an accepted frame
  a_r6_auto_pair: assert property (@(posedge clk) disable iff (!rst_n)
    auto_conn_o |-> (accept_o && hi_hit_o == 2'd2 && !lo_hit_o));
  // R2: a reject carries zero hit codes
  a_r2_reject_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld_o && !accept_o) |-> (hi_hit_o == 2'd0 && !lo_hit_o));
  // R8: extracted bit held between decision and next start-of-frame
  a_r8_cr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_vld_o && !$past(sof_i)) |-> $stable(cr_bit_o));
  // R4: address-less mode always accepts
  a_r4_none_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld_o && cfg_q.mode == AM_NONE) |-> accept_o);
  // R10: one decision per frame
  a_r10_single_dec: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |=> !dec_vld_o);
endmodule

// File: tb/hdlc_addr_screen_tb_top.sv
`timescale 1ns/1ps
module hdlc_addr_screen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof_i = 0, byte_vld_i = 0, eof_i = 0, cr_en_i = 0;
  logic [7:0] byte_i = 0, hi_set1_i = 0, hi_set2_i = 0, lo_set1_i = 0, lo_set2_i = 0;
  logic [1:0] mode_i = 0;
  logic dec_vld_o, accept_o, lo_hit_o, cr_bit_o, auto_conn_o, abort_o;
  logic [1:0] hi_hit_o;

  always #2 clk = ~clk;

  hdlc_addr_screen dut_i (.*);

  typedef struct {
    logic abort; logic acc; logic [1:0] hi; logic lo; logic cr; logic aut; string tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic wd_hit = 0;

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // independent reference: mode 0 none, 1 one byte, 2/3 two bytes
  function automatic exp_t model(input logic [1:0] m, input logic cre, input logic [7:0] h1, h2, l1, l2,
                                 input logic [7:0] b0, b1, input int n, input string tag);
    exp_t e;
    logic [6:0] k0, g, p1, p2;
    e.abort = 0; e.acc = 0; e.hi = 0; e.lo = 0; e.cr = 0; e.aut = 0; e.tag = tag;
    if (n < ((m < 2) ? 1 : 2)) begin e.abort = 1; return e; end
    if (m == 0) begin e.acc = 1; return e; end
    k0 = {b0[7:2], b0[0]}; g = 7'b1111110; p1 = {h1[7:2], h1[0]}; p2 = {h2[7:2], h2[0]};
    if (cre ? (k0 == g) : (b0 == 8'hFE)) e.hi = 1;
    else if (cre ? (k0 == p1) : (b0 == h1)) e.hi = 2;
    else if (cre ? (k0 == p2) : (b0 == h2)) e.hi = 3;
    e.cr = cre ? b0[1] : 1'b0;
    if (m == 1) begin e.acc = (e.hi != 0); return e; end
    e.acc = (e.hi != 0) && (b1 == l1 || b1 == l2);
    if (!e.acc) begin e.hi = 0; return e; end
    e.lo = (b1 != l1);
    e.aut = (m == 3) && (e.hi == 2) && !e.lo;
    return e;
  endfunction

  // monitor: pop and compare on every decision or abort
  always @(negedge clk) begin
    if (rst_n && (dec_vld_o || abort_o)) begin
      if (sb.size() == 0) begin
        chk("R10 unexpected decision", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " R7 abort"}, int'(abort_o), int'(e.abort));
        if (!e.abort) begin
          chk({e.tag, " R1 accept"}, int'(accept_o), int'(e.acc));
          chk({e.tag, " R2 hi_hit"}, int'(hi_hit_o), int'(e.hi));
          chk({e.tag, " R2 lo_hit"}, int'(lo_hit_o), int'(e.lo));
          chk({e.tag, " R3 cr_bit"}, int'(cr_bit_o), int'(e.cr));
          chk({e.tag, " R6 auto"}, int'(auto_conn_o), int'(e.aut));
        end
      end
    end
  end

  task automatic frame(input logic [1:0] m, input logic cre, input logic [7:0] h1, h2, l1, l2,
                       input logic [7:0] b0, b1, input int n, input bit mid, input string tag);
    exp_t e;
    e = model(m, cre, h1, h2, l1, l2, b0, b1, n, tag);
    sb.push_back(e);
    @(negedge clk);
    mode_i = m; cr_en_i = cre; hi_set1_i = h1; hi_set2_i = h2; lo_set1_i = l1; lo_set2_i = l2;
    sof_i = 1;
    @(negedge clk);
    sof_i = 0;
    if (mid) begin  // R9: scramble settings mid-frame
      mode_i = 2'd0; cr_en_i = ~cre; hi_set1_i = 8'h00; hi_set2_i = 8'h00; lo_set1_i = 8'h00; lo_set2_i = 8'h00;
    end
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1; byte_i = (i == 0) ? b0 : b1;
      @(negedge clk);
    end
    if (n >= 2 || (m < 2 && n >= 1)) begin  // R10: trailing byte after decision
      byte_vld_i = 1; byte_i = b0;
      @(negedge clk);
    end
    byte_vld_i = 0;
    eof_i = 1;
    @(negedge clk);
    eof_i = 0;
    repeat (2) @(negedge clk);
    chk({tag, " R8 cr held"}, int'(cr_bit_o), e.abort ? 0 : int'(e.cr));
    chk({tag, " R8 accept held"}, int'(accept_o), e.abort ? 0 : int'(e.acc));
    chk({tag, " R1 scoreboard drained"}, sb.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset accept", int'(accept_o), 0);
    chk("R8 reset dec_vld", int'(dec_vld_o), 0);
    chk("R7 reset abort", int'(abort_o), 0);
    // stray byte outside any frame: R10
    byte_vld_i = 1; byte_i = 8'h12; @(negedge clk); byte_vld_i = 0; @(negedge clk);
    chk("R10 idle byte", int'(dec_vld_o), 0);

    frame(0, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h99, 8'h00, 1, 0, "R4 none");
    frame(1, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h00, 1, 0, "R5 byte set1");
    frame(1, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'hFE, 8'h00, 1, 0, "R5 byte group");
    frame(1, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'hFC, 8'h00, 1, 0, "R3 FC exact miss");
    frame(1, 1, 8'h12, 8'h34, 8'h56, 8'h78, 8'hFC, 8'h00, 1, 0, "R3 FC masked");
    frame(1, 1, 8'h12, 8'h34, 8'h56, 8'h78, 8'hFE, 8'h00, 1, 0, "R3 FE cr1");
    frame(2, 1, 8'h12, 8'h34, 8'h56, 8'h78, 8'h10, 8'h56, 2, 0, "R3 set1 masked");
    frame(2, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h10, 8'h56, 2, 0, "R3 set1 exact miss");
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 2; l++)
        frame(2, 0, 8'h12, 8'h34, 8'h56, 8'h78, (h == 0) ? 8'hFE : (h == 1) ? 8'h12 : 8'h34,
              l ? 8'h78 : 8'h56, 2, 0, "R1 combo");
    frame(2, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h55, 8'h56, 2, 0, "R1 hi miss");
    frame(2, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h99, 2, 0, "R1 lo miss");
    frame(3, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h56, 2, 0, "R6 auto pair");
    frame(3, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h78, 2, 0, "R6 set1 lo2");
    frame(3, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h34, 8'h56, 2, 0, "R6 set2 lo1");
    frame(3, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'hFE, 8'h56, 2, 0, "R6 group lo1");
    frame(1, 0, 8'hFE, 8'h34, 8'h56, 8'h78, 8'hFE, 8'h00, 1, 0, "R2 group over set1");
    frame(2, 0, 8'h12, 8'h12, 8'h56, 8'h56, 8'h12, 8'h56, 2, 0, "R2 set1 over set2");
    frame(2, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h00, 1, 0, "R7 one byte");
    frame(1, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h00, 0, 0, "R7 empty");
    frame(3, 0, 8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h56, 2, 1, "R9 cfg change");
    frame(1, 1, 8'h12, 8'h34, 8'h56, 8'h78, 8'hFE, 8'h00, 1, 1, "R9 cfg change byte");

    repeat (4) @(negedge clk);
    chk("R10 queue empty at end", sb.size(), 0);
    if (!wd_hit) begin
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule